// File: doc/BRIEF.md
# OR-with-Inverted-Immediate Execute Slice

This block decodes one 32-bit instruction made of two halfwords and, when it recognises the OR-with-inverted-immediate opcode, executes it. It combines a register operand with the bitwise complement of a 32-bit constant. That constant is expanded from a 12-bit packed immediate. The block produces the value to write back, the destination index and write enable, and a mask of the condition flags to update together with their new values. It does not store registers, evaluate condition codes or fetch instructions. The surrounding pipeline supplies the operand that was read for the source index, plus the current carry flag.

An instruction enters on a valid/ready handshake and its outcome leaves one cycle later on a second valid/ready handshake. The block holds one result. Back-pressure rules:
- `in_ready` is high whenever the output slot is empty, or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, every output holds its value and no input is accepted.

The block also raises three flags on the output:
- one that hands the instruction over to the move-inverted-immediate operation;
- one for a destination index that is not allowed;
- one for an immediate encoding that is not allowed.

Top module: `ornot_exec`

## Requirements
- R1: The opcode matches when instr[31:27]=11110, instr[25]=0, instr[24:21]=0011 and instr[15]=0; `out_match` reports this. A non-matching word gives `out_wr_en`=0, `out_flag_we`=0 and no error or redirect flag.
- R2: For an executed instruction, `out_result` equals the source operand OR the bitwise NOT of the expanded constant. `out_wr_idx` is instr[11:8].
- R3: When the source index instr[19:16] is 15, `out_movnot` is 1 and both `out_wr_en` and `out_flag_we` are 0.
- R4: A destination index of 15 sets `out_bad_dst` and clears `out_wr_en` and `out_flag_we`. A destination index of 13 writes normally.
- R5: The packed immediate is k = {instr[26], instr[14:12], instr[7:0]}, and b = k[7:0]. When k[11:10]=00, k[9:8] selects the constant:
  - 00 gives b zero-extended;
  - 01 gives b in bytes 0 and 2;
  - 10 gives b in bytes 1 and 3;
  - 11 gives b in all four bytes.
  In every one of these cases the expansion carry equals `carry_in`.
- R6: When k[11:10]≠00, the constant is {1, b[6:0]} zero-extended and rotated right by k[11:7]. The expansion carry is bit 31 of that constant.
- R7: When k[11:10]=00, k[9:8]≠00 and b=0, `out_bad_imm` is 1 and both `out_wr_en` and `out_flag_we` are 0.
- R8: When instr[20]=1 and the instruction executes, `out_flag_we`=1110. The bit order of `out_flag_we` is [3]=N, [2]=Z, [1]=C, [0]=V. The new values are:
  - `out_n` = result bit 31;
  - `out_z` = 1 exactly when the result is zero;
  - `out_c` = the expansion carry.
- R9: When instr[20]=0, `out_flag_we` is 0000. Bit 0 (V) of `out_flag_we` is never 1.
- R10: An input accepted at a clock edge appears on the outputs with `out_valid`=1 after that edge. While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and all outputs hold their values.
- R11: A synchronous active-high reset clears `out_valid`, `out_flag_we`, `out_n`, `out_z` and `out_c`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input instruction is present |
| in_ready | output | 1 | Block can accept an instruction |
| in_instr | input | 32 | Instruction; first halfword in [31:16] |
| src_val | input | 32 | Operand read for the source index |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Outputs hold a result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Value to write back |
| out_wr_en | output | 1 | Register write enable |
| out_wr_idx | output | 4 | Destination register index |
| out_flag_we | output | 4 | Flag update mask, [3]=N [2]=Z [1]=C [0]=V |
| out_n | output | 1 | New negative flag |
| out_z | output | 1 | New zero flag |
| out_c | output | 1 | New carry flag |
| out_match | output | 1 | Opcode recognised |
| out_movnot | output | 1 | Redirect to move-inverted-immediate |
| out_bad_dst | output | 1 | Destination index 15 rejected |
| out_bad_imm | output | 1 | Immediate encoding rejected |

## Verification
On every cycle the assertions check the following:
- the negative and zero values agree with the result whenever their update bits are set;
- V is never in the update mask;
- redirected, rejected-destination and non-matching outputs never write;
- a stalled output holds steady while the input side stays closed;
- reset empties the output.

Only the bench's scenarios can show the remaining behaviour:
- that the constant is expanded correctly for each replicate pattern and for the rotation amounts tried;
- that the carry is chosen correctly between the incoming flag and the rotated bit;
- that the result value itself is right;
- that index 13 is accepted.

// File: rtl/ornot_pkg.sv
package ornot_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned IMM_W   = 12;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FLAG_N  = 4;
  localparam int unsigned ROT_W   = 5;

  // flag mask bit positions
  localparam int unsigned FB_N = 3;
  localparam int unsigned FB_Z = 2;
  localparam int unsigned FB_C = 1;
  localparam int unsigned FB_V = 0;

  localparam logic [IDX_W-1:0] IDX_ALL_ONES = '1;

  typedef struct packed {
    logic              imm_hi;
    logic              set_flags;
    logic [IDX_W-1:0]  src_idx;
    logic [2:0]        imm_mid;
    logic [IDX_W-1:0]  dst_idx;
    logic [BYTE_W-1:0] imm_lo;
  } fields_t;

  typedef struct packed {
    logic [WORD_W-1:0] result;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [FLAG_N-1:0] flag_we;
    logic              n;
    logic              z;
    logic              c;
    logic              match;
    logic              movnot;
    logic              bad_dst;
    logic              bad_imm;
  } exec_out_t;
endpackage

// File: rtl/ornot_decode.sv
module ornot_decode
  import ornot_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output fields_t           fld,
  output logic              match,
  output logic              redirect,
  output logic              dst_bad
);
  logic [15:0] hw_first;
  logic [15:0] hw_second;

  always_comb begin
    hw_first  = instr[WORD_W-1:16];
    hw_second = instr[15:0];
    fld.imm_hi    = hw_first[10];
    fld.set_flags = hw_first[4];
    fld.src_idx   = hw_first[3:0];
    fld.imm_mid   = hw_second[14:12];
    fld.dst_idx   = hw_second[11:8];
    fld.imm_lo    = hw_second[7:0];
  end

  // fixed opcode bits of both halfwords
  always_comb begin
    match = (hw_first[15:11] == 5'b11110) &&
            (hw_first[9] == 1'b0) &&
            (hw_first[8:5] == 4'b0011) &&
            (hw_second[15] == 1'b0);
  end

  always_comb begin
    redirect = match && (fld.src_idx == IDX_ALL_ONES);
    dst_bad  = match && !redirect && (fld.dst_idx == IDX_ALL_ONES);
  end
endmodule

// File: rtl/ornot_imm_expand.sv
module ornot_imm_expand
  import ornot_pkg::*;
#(
  parameter int unsigned OUT_W = WORD_W,
  parameter int unsigned K_W   = IMM_W
) (
  input  logic [K_W-1:0]   k,
  input  logic             carry_in,
  output logic [OUT_W-1:0] value,
  output logic             carry_out,
  output logic             pattern_bad
);
  localparam int unsigned NBYTES = OUT_W / BYTE_W;
  localparam int unsigned STAGES = ROT_W;

  logic [BYTE_W-1:0] b;
  logic [1:0]        sel;
  logic              replicate;
  logic [ROT_W-1:0]  amount;
  logic [OUT_W-1:0]  rep_val;

  assign b         = k[BYTE_W-1:0];
  assign sel       = k[9:8];
  assign replicate = (k[11:10] == 2'b00);
  assign amount    = k[11:7];

  // byte lanes for the replicate forms
  for (genvar gi = 0; gi < NBYTES; gi++) begin : g_lane
    logic lane_on;
    always_comb begin
      unique case (sel)
        2'b00:   lane_on = (gi == 0);
        2'b01:   lane_on = ((gi % 2) == 0);
        2'b10:   lane_on = ((gi % 2) == 1);
        default: lane_on = 1'b1;
      endcase
    end
    assign rep_val[gi*BYTE_W +: BYTE_W] = lane_on ? b : '0;
  end

  // logarithmic right rotator for the rotated form
  logic [OUT_W-1:0] stage [STAGES+1];
  assign stage[0] = {{(OUT_W-BYTE_W){1'b0}}, 1'b1, b[BYTE_W-2:0]};

  for (genvar gs = 0; gs < STAGES; gs++) begin : g_rot
    localparam int unsigned SH = 1 << gs;
    assign stage[gs+1] = amount[gs]
      ? {stage[gs][SH-1:0], stage[gs][OUT_W-1:SH]}
      : stage[gs];
  end

  always_comb begin
    if (replicate) begin
      value       = rep_val;
      carry_out   = carry_in;
      pattern_bad = (sel != 2'b00) && (b == '0);
    end else begin
      value       = stage[STAGES];
      carry_out   = stage[STAGES][OUT_W-1];
      pattern_bad = 1'b0;
    end
  end
endmodule

// File: rtl/ornot_alu_flags.sv
module ornot_alu_flags
  import ornot_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] imm_val,
  input  logic          imm_carry,
  output logic [DW-1:0] result,
  output logic          neg,
  output logic          zero,
  output logic          carry
);
  always_comb begin
    result = operand | ~imm_val;
    neg    = result[DW-1];
    zero   = (result == '0);
    carry  = imm_carry;
  end
endmodule

// File: rtl/ornot_out_stage.sv
module ornot_out_stage
  import ornot_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      in_valid,
  output logic      in_ready,
  input  exec_out_t din,
  output logic      out_valid,
  input  logic      out_ready,
  output exec_out_t dout
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take)     dout      <= din;
    end
  end
endmodule

// File: rtl/ornot_exec.sv
module ornot_exec
  import ornot_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_instr,
  input  logic [WORD_W-1:0] src_val,
  input  logic              carry_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result,
  output logic              out_wr_en,
  output logic [IDX_W-1:0]  out_wr_idx,
  output logic [FLAG_N-1:0] out_flag_we,
  output logic              out_n,
  output logic              out_z,
  output logic              out_c,
  output logic              out_match,
  output logic              out_movnot,
  output logic              out_bad_dst,
  output logic              out_bad_imm
);
  fields_t           fld;
  logic              match, redirect, dst_bad;
  logic [IMM_W-1:0]  k;
  logic [WORD_W-1:0] imm_val, result;
  logic              imm_carry, pat_bad, imm_bad;
  logic              neg, zero, carry, executes;
  exec_out_t         nxt, held;

  ornot_decode u_dec (
    .instr    (in_instr),
    .fld      (fld),
    .match    (match),
    .redirect (redirect),
    .dst_bad  (dst_bad)
  );

  assign k = {fld.imm_hi, fld.imm_mid, fld.imm_lo};

  ornot_imm_expand #(.OUT_W(WORD_W), .K_W(IMM_W)) u_exp (
    .k           (k),
    .carry_in    (carry_in),
    .value       (imm_val),
    .carry_out   (imm_carry),
    .pattern_bad (pat_bad)
  );

  ornot_alu_flags #(.DW(WORD_W)) u_alu (
    .operand   (src_val),
    .imm_val   (imm_val),
    .imm_carry (imm_carry),
    .result    (result),
    .neg       (neg),
    .zero      (zero),
    .carry     (carry)
  );

  always_comb begin
    imm_bad  = match && !redirect && pat_bad;
    executes = match && !redirect && !dst_bad && !imm_bad;

    nxt            = '0;
    nxt.result     = result;
    nxt.wr_en      = executes;
    nxt.wr_idx     = fld.dst_idx;
    nxt.n          = neg;
    nxt.z          = zero;
    nxt.c          = carry;
    nxt.match      = match;
    nxt.movnot     = redirect;
    nxt.bad_dst    = dst_bad;
    nxt.bad_imm    = imm_bad;
    if (executes && fld.set_flags) begin
      nxt.flag_we[FB_N] = 1'b1;
      nxt.flag_we[FB_Z] = 1'b1;
      nxt.flag_we[FB_C] = 1'b1;
    end
    nxt.flag_we[FB_V] = 1'b0;
  end

  ornot_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .din       (nxt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .dout      (held)
  );

  always_comb begin
    out_result  = held.result;
    out_wr_en   = held.wr_en;
    out_wr_idx  = held.wr_idx;
    out_flag_we = held.flag_we;
    out_n       = held.n;
    out_z       = held.z;
    out_c       = held.c;
    out_match   = held.match;
    out_movnot  = held.movnot;
    out_bad_dst = held.bad_dst;
    out_bad_imm = held.bad_imm;
  end
endmodule

// File: rtl/ornot_exec_chk.sv
module ornot_exec_chk
  import ornot_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_result,
  input logic              out_wr_en,
  input logic [IDX_W-1:0]  out_wr_idx,
  input logic [FLAG_N-1:0] out_flag_we,
  input logic              out_n,
  input logic              out_z,
  input logic              out_match,
  input logic              out_movnot,
  input logic              out_bad_dst,
  input logic              out_bad_imm
);
  a_r1_nomatch_quiet: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_match |-> !out_wr_en && out_flag_we == '0 && !out_movnot);

  a_r3_redirect_no_write: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_movnot |-> !out_wr_en && out_flag_we == '0);

  a_r4_dst15_no_write: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_match && !out_movnot && out_wr_idx == IDX_ALL_ONES
      |-> out_bad_dst && !out_wr_en);

  a_r7_bad_imm_no_write: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_bad_imm |-> !out_wr_en && out_flag_we == '0);

  a_r8_neg_matches: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_flag_we[FB_N] |-> out_n == out_result[WORD_W-1]);

  a_r8_zero_matches: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_flag_we[FB_Z] |-> out_z == (out_result == '0));

  a_r9_v_untouched: assert property (@(posedge clk) disable iff (rst)
    !out_flag_we[FB_V]);

  a_r10_stall_closed: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
      $stable(out_wr_en) && $stable(out_flag_we) && $stable(out_wr_idx));

  a_r11_reset_empty: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && out_flag_we == '0);
endmodule

bind ornot_exec ornot_exec_chk i_chk (.*);

// File: tb/test_ornot_exec.sv
`timescale 1ns/1ps
module test_ornot_exec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [31:0] src_val = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_wr_en;
  logic [3:0]  out_wr_idx;
  logic [3:0]  out_flag_we;
  logic        out_n, out_z, out_c;
  logic        out_match, out_movnot, out_bad_dst, out_bad_imm;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  always #2 clk = ~clk;

  ornot_exec i_ornot_exec (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [31:0] mk(input logic i, input logic s,
      input logic [3:0] src, input logic [2:0] i3,
      input logic [3:0] dst, input logic [7:0] i8);
    return {5'b11110, i, 1'b0, 4'b0011, s, src, 1'b0, i3, dst, i8};
  endfunction

  // {carry, constant} from the expansion rules
  function automatic logic [32:0] ref_expand(input logic [11:0] k, input logic cin);
    logic [7:0]  b;
    logic [31:0] v;
    logic [63:0] d;
    b = k[7:0];
    if (k[11:10] == 2'b00) begin
      case (k[9:8])
        2'b00:   v = {24'd0, b};
        2'b01:   v = {8'd0, b, 8'd0, b};
        2'b10:   v = {b, 8'd0, b, 8'd0};
        default: v = {b, b, b, b};
      endcase
      return {cin, v};
    end
    v = {24'd0, 1'b1, b[6:0]};
    d = {v, v} >> k[11:7];
    return {d[31], d[31:0]};
  endfunction

  // one transfer with the output side open, then compare all outputs
  task automatic exec_check(input string req, input logic [31:0] ins,
                            input logic [31:0] src, input logic cin);
    logic        m, redir, bdst, bimm, ex, s;
    logic [11:0] k;
    logic [32:0] e;
    logic [31:0] res;
    logic [3:0]  mask;
    m     = ins[31:27] == 5'b11110 && !ins[25] && ins[24:21] == 4'b0011 && !ins[15];
    redir = m && ins[19:16] == 4'hF;
    bdst  = m && !redir && ins[11:8] == 4'hF;
    k     = {ins[26], ins[14:12], ins[7:0]};
    e     = ref_expand(k, cin);
    bimm  = m && !redir && k[11:10] == 2'b00 && k[9:8] != 2'b00 && k[7:0] == 8'h00;
    ex    = m && !redir && !bdst && !bimm;
    s     = ins[20];
    res   = src | ~e[31:0];
    mask  = (ex && s) ? 4'b1110 : 4'b0000;

    @(negedge clk);
    in_instr = ins; src_val = src; carry_in = cin;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "out_valid", {31'd0, out_valid}, 32'd1);
    check(req, "match", {31'd0, out_match}, {31'd0, m});
    check(req, "movnot", {31'd0, out_movnot}, {31'd0, redir});
    check(req, "bad_dst", {31'd0, out_bad_dst}, {31'd0, bdst});
    check(req, "bad_imm", {31'd0, out_bad_imm}, {31'd0, bimm});
    check(req, "wr_en", {31'd0, out_wr_en}, {31'd0, ex});
    check(req, "flag_we", {28'd0, out_flag_we}, {28'd0, mask});
    if (ex) begin
      check(req, "result", out_result, res);
      check(req, "wr_idx", {28'd0, out_wr_idx}, {28'd0, ins[11:8]});
    end
    if (ex && s) begin
      check(req, "n", {31'd0, out_n}, {31'd0, res[31]});
      check(req, "z", {31'd0, out_z}, {31'd0, res == 32'd0});
      check(req, "c", {31'd0, out_c}, {31'd0, e[32]});
    end
  endtask

  task automatic t_reset();
    check("R11", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R11", "flag_we after reset", {28'd0, out_flag_we}, 32'd0);
    check("R11", "nzc after reset", {29'd0, out_n, out_z, out_c}, 32'd0);
    check("R10", "in_ready empty", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_replicate();
    exec_check("R5", mk(0, 1, 4'd2, 3'b000, 4'd1, 8'hA5), 32'h0000_0000, 1'b1);
    exec_check("R5", mk(0, 1, 4'd2, 3'b001, 4'd1, 8'h3C), 32'h1200_0000, 1'b0);
    exec_check("R5", mk(0, 1, 4'd2, 3'b010, 4'd1, 8'h3C), 32'h0000_0001, 1'b1);
    exec_check("R5", mk(0, 1, 4'd2, 3'b011, 4'd1, 8'h3C), 32'hC3C3_C3C3, 1'b1);
    exec_check("R2", mk(0, 1, 4'd4, 3'b000, 4'd6, 8'h00), 32'h1234_5678, 1'b0);
  endtask

  task automatic t_rotate();
    exec_check("R6", mk(0, 1, 4'd3, 3'b100, 4'd2, 8'h00), 32'h0000_0000, 1'b0);
    exec_check("R6", mk(0, 1, 4'd3, 3'b100, 4'd2, 8'h80), 32'h0F0F_0000, 1'b1);
    exec_check("R6", mk(1, 1, 4'd3, 3'b000, 4'd2, 8'h55), 32'h0000_0000, 1'b1);
    exec_check("R6", mk(1, 1, 4'd3, 3'b111, 4'd2, 8'hFF), 32'h8000_0000, 1'b0);
    exec_check("R6", mk(0, 1, 4'd3, 3'b110, 4'd2, 8'h7E), 32'hFFFF_0000, 1'b0);
  endtask

  task automatic t_flags();
    exec_check("R8", mk(0, 1, 4'd1, 3'b011, 4'd5, 8'hFF), 32'h0000_0000, 1'b1);
    exec_check("R8", mk(0, 1, 4'd1, 3'b011, 4'd5, 8'hFF), 32'h8000_0000, 1'b0);
    exec_check("R9", mk(0, 0, 4'd1, 3'b100, 4'd5, 8'h80), 32'h0000_0000, 1'b1);
    exec_check("R9", mk(0, 0, 4'd1, 3'b001, 4'd5, 8'h11), 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_indices();
    exec_check("R3", mk(0, 1, 4'hF, 3'b000, 4'd3, 8'h12), 32'hAAAA_AAAA, 1'b1);
    exec_check("R4", mk(0, 1, 4'd7, 3'b000, 4'hF, 8'h12), 32'h5555_5555, 1'b1);
    exec_check("R4", mk(0, 1, 4'd7, 3'b000, 4'd13, 8'h12), 32'h5555_5555, 1'b1);
  endtask

  task automatic t_bad_imm();
    exec_check("R7", mk(0, 1, 4'd2, 3'b001, 4'd4, 8'h00), 32'h0000_0000, 1'b1);
    exec_check("R7", mk(0, 1, 4'd2, 3'b010, 4'd4, 8'h00), 32'h0000_0000, 1'b0);
    exec_check("R7", mk(0, 1, 4'd2, 3'b011, 4'd4, 8'h00), 32'h0000_0000, 1'b1);
  endtask

  task automatic t_nomatch();
    logic [31:0] w;
    w = mk(0, 1, 4'd2, 3'b000, 4'd4, 8'h01);
    w[24:21] = 4'b0010;
    exec_check("R1", w, 32'h0, 1'b0);
    w = mk(0, 1, 4'd2, 3'b000, 4'd4, 8'h01);
    w[15] = 1'b1;
    exec_check("R1", w, 32'h0, 1'b0);
  endtask

  task automatic t_backpressure();
    logic [31:0] first;
    first = 32'h0000_00F0 | ~32'h0000_0011;
    @(negedge clk);
    in_instr = mk(0, 0, 4'd1, 3'b000, 4'd9, 8'h11);
    src_val = 32'h0000_00F0; carry_in = 1'b0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check("R10", "valid after accept", {31'd0, out_valid}, 32'd1);
    check("R10", "in_ready closed", {31'd0, in_ready}, 32'd0);
    in_instr = mk(0, 0, 4'd1, 3'b000, 4'd8, 8'h22);
    src_val = 32'h0;
    @(negedge clk);
    check("R10", "result held", out_result, first);
    check("R10", "wr_idx held", {28'd0, out_wr_idx}, 32'd9);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R10", "drained", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    in_instr = mk(0, 1, 4'd1, 3'b000, 4'd2, 8'h00);
    src_val = 32'h0; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; out_ready = 1'b1;
    check("R11", "valid cleared", {31'd0, out_valid}, 32'd0);
    check("R11", "mask cleared", {28'd0, out_flag_we}, 32'd0);
    check("R11", "nzc cleared", {29'd0, out_n, out_z, out_c}, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_replicate();
    t_rotate();
    t_flags();
    t_indices();
    t_bad_imm();
    t_nomatch();
    t_backpressure();
    t_reset_mid();
    repeat (2) @(negedge clk);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish");
    report();
  end
endmodule